// File: doc/BRIEF.md
# Two-Dimensional Stride Address Generator

This block produces the addresses and beat counts for a block copy. The copy is laid out as a number of rows, and each row is a number of bytes. A load pulse captures a source start address, a destination start address, a packed length word, a packed stride word and a mode bit. Each later step pulse stands for one four-byte beat. On each beat the block moves the source and destination addresses forward, each one only if its own increment enable is high, and it reduces the byte count left in the current row.

When a row ends and more rows follow, a signed per-row stride is added to each address and the byte count is reloaded. The block drives the current addresses, a flag marking the last beat of a row, a done flag, and a packed remaining-length word for readback. The memory accesses and the fetching of transfer descriptors sit outside the block, in the engine that issues the beats.

Top module: `stride2d_agen`

## Requirements
- R1: After reset, done is 1, both addresses are 0, remaining length is 0 and last-in-row is 0.
- R2: A load with the mode bit high (2D) captures the row count from length bits [29:16] and the per-row byte count from bits [15:0]. From the next cycle the addresses equal the loaded values and remaining length reads {2'b00, rows[13:0], bytes[15:0]}.
- R3: A load with the mode bit low (1D) uses one row, takes the full 32-bit length as the byte count, and uses zero strides. Remaining length then reads the byte count alone.
- R4: A load whose row count or byte count is zero sets done in the next cycle, and no beat follows.
- R5: Each step taken while not done lowers the byte count by 4. It adds 4 to the source address only when the source increment enable is high, and to the destination address only when the destination increment enable is high.
- R6: When the beat that ends a row is taken and more than one row is left, the following happen in the same cycle as that beat's increments. The signed upper 16 bits of the stride word are added to the destination address. The signed lower 16 bits are added to the source address. The row count falls by 1, and the byte count reloads from the per-row value.
- R7: The beat that ends the final row adds no stride and sets done. It leaves remaining length at rows=1 with bytes=0 in 2D, and at 0 in 1D.
- R8: Last-in-row is high exactly when the block is not done and the byte count left is 4 or less.
- R9: A step while done changes neither address nor remaining length.
- R10: A load takes priority over a step in the same cycle, and it restarts the transfer from the new values.
- R11: A beat taken with fewer than 4 bytes left ends the row, and the byte count stops at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Captures the transfer parameters |
| is2d | input | 1 | Mode bit at load: 1 = rows-by-bytes, 0 = linear |
| srcAddrIn | input | 32 | Source start address |
| dstAddrIn | input | 32 | Destination start address |
| lenWord | input | 32 | Packed length word |
| strideWord | input | 32 | Packed stride word: upper half destination, lower half source |
| srcInc | input | 1 | Source advances by 4 on each beat |
| dstInc | input | 1 | Destination advances by 4 on each beat |
| step | input | 1 | One beat taken |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| lastInRow | output | 1 | The current beat is the last of its row |
| done | output | 1 | No beats remain |
| remainLen | output | 32 | Packed remaining length |

## Verification
Every result is registered, so a load or step applied before a rising edge is visible on all outputs after that single edge. Last-in-row is decoded from the registered counters and settles in the same cycle as the counters do. The driver applies stimulus on the falling edge and queues the expected state for that edge. The monitor pops and compares one nanosecond after the next rising edge, which is exactly one register stage later, and compares all five outputs in each item.

// File: rtl/stride2d_pkg.sv
package stride2d_pkg;
  // Strobes from the control to each address lane
  typedef struct packed {
    logic ld;       // capture start address and stride
    logic beat;     // one beat taken
    logic rowWrap;  // beat closes a row and more rows follow
  } agen_strb_t;
endpackage

// File: rtl/stride2d_ctrl.sv
module stride2d_ctrl
  import stride2d_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int ROW_W      = 14,
  parameter int COL_W      = 16,
  parameter int ROW_LSB    = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             is2d,
  input  logic [LEN_W-1:0] lenWord,
  input  logic             step,
  output agen_strb_t       strb,
  output logic             lastInRow,
  output logic             done,
  output logic [LEN_W-1:0] remainLen
);
  localparam int PAD_W = LEN_W - ROW_LSB - ROW_W;
  localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);

  logic [ROW_W-1:0] rowsQ;
  logic [LEN_W-1:0] bytesQ, reloadQ;
  logic             modeQ, doneQ;

  logic [ROW_W-1:0] rowsLd;
  logic [LEN_W-1:0] bytesLd;
  logic             endRow, moreRows, beatTaken;

  always_comb begin
    rowsLd  = is2d ? lenWord[ROW_LSB +: ROW_W] : ROW_W'(1);
    bytesLd = is2d ? {{(LEN_W-COL_W){1'b0}}, lenWord[COL_W-1:0]} : lenWord;
  end

  assign endRow    = (bytesQ <= BEAT_L);
  assign moreRows  = (rowsQ > ROW_W'(1));
  assign beatTaken = step && !load && !doneQ;

  always_comb begin
    strb.ld      = load;
    strb.beat    = beatTaken;
    strb.rowWrap = beatTaken && endRow && moreRows;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowsQ   <= '0;
      bytesQ  <= '0;
      reloadQ <= '0;
      modeQ   <= 1'b0;
      doneQ   <= 1'b1;
    end else if (load) begin
      rowsQ   <= rowsLd;
      bytesQ  <= bytesLd;
      reloadQ <= bytesLd;
      modeQ   <= is2d;
      doneQ   <= (rowsLd == '0) || (bytesLd == '0);
    end else if (beatTaken) begin
      if (!endRow) begin
        bytesQ <= bytesQ - BEAT_L;
      end else if (moreRows) begin
        rowsQ  <= rowsQ - ROW_W'(1);
        bytesQ <= reloadQ;
      end else begin
        bytesQ <= '0;
        doneQ  <= 1'b1;
      end
    end
  end

  assign done      = doneQ;
  assign lastInRow = !doneQ && endRow;
  assign remainLen = modeQ ? {{PAD_W{1'b0}}, rowsQ, bytesQ[COL_W-1:0]} : bytesQ;

  // R9: done persists until the next load
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !load) |=> doneQ);
  // R5: a mid-row beat lowers the byte count by one beat
  assert_byte_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && !doneQ && (bytesQ > BEAT_L)) |=> (bytesQ == $past(bytesQ) - BEAT_L));
  // R6: the row count never rises without a load
  assert_rows_monotone_R6: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> (rowsQ <= $past(rowsQ)));
  // R7: the final beat of the final row sets done
  assert_final_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && !doneQ && endRow && !moreRows) |=> doneQ);
  // R4: zero-size load finishes at once
  assert_zero_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (load && ((rowsLd == '0) || (bytesLd == '0))) |=> doneQ);
endmodule

// File: rtl/stride2d_addr_lane.sv
module stride2d_addr_lane
  import stride2d_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  agen_strb_t          strb,
  input  logic                is2d,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [STRIDE_W-1:0] strideField,
  input  logic                incEn,
  output logic [ADDR_W-1:0]   addr
);
  localparam logic [ADDR_W-1:0] BEAT_A = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] addrQ, strideQ, stepAdd, nextAddr;

  always_comb begin
    stepAdd  = incEn ? BEAT_A : '0;
    nextAddr = addrQ + stepAdd;
    if (strb.rowWrap) nextAddr = nextAddr + strideQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      strideQ <= '0;
    end else if (strb.ld) begin
      addrQ   <= startAddr;
      strideQ <= is2d ? {{(ADDR_W-STRIDE_W){strideField[STRIDE_W-1]}}, strideField} : '0;
    end else if (strb.beat) begin
      addrQ <= nextAddr;
    end
  end

  assign addr = addrQ;

  // R9: no beat and no load leaves the address alone
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ld && !strb.beat) |=> $stable(addrQ));
  // R5: a beat inside a row moves the address by one beat or not at all
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.beat && !strb.ld && !strb.rowWrap) |=>
      ((addrQ == $past(addrQ) + BEAT_A) || (addrQ == $past(addrQ))));
  // R10: load and beat strobes never coincide
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ld, strb.beat}));
endmodule

// File: rtl/stride2d_agen.sv
module stride2d_agen
  import stride2d_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int ROW_W      = 14,
  parameter int COL_W      = 16,
  parameter int STRIDE_W   = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              is2d,
  input  logic [ADDR_W-1:0] srcAddrIn,
  input  logic [ADDR_W-1:0] dstAddrIn,
  input  logic [LEN_W-1:0]  lenWord,
  input  logic [2*STRIDE_W-1:0] strideWord,
  input  logic              srcInc,
  input  logic              dstInc,
  input  logic              step,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              lastInRow,
  output logic              done,
  output logic [LEN_W-1:0]  remainLen
);
  localparam int NLANE   = 2;  // lane 0 source, lane 1 destination
  localparam int ROW_LSB = COL_W;

  agen_strb_t        strb;
  logic [ADDR_W-1:0] laneStart [NLANE];
  logic [ADDR_W-1:0] laneAddr  [NLANE];
  logic              laneInc   [NLANE];

  assign laneStart[0] = srcAddrIn;
  assign laneStart[1] = dstAddrIn;
  assign laneInc[0]   = srcInc;
  assign laneInc[1]   = dstInc;

  stride2d_ctrl #(
    .LEN_W(LEN_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ROW_LSB(ROW_LSB), .BEAT_BYTES(BEAT_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .load(load), .is2d(is2d), .lenWord(lenWord),
    .step(step), .strb(strb), .lastInRow(lastInRow), .done(done),
    .remainLen(remainLen)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    stride2d_addr_lane #(
      .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .BEAT_BYTES(BEAT_BYTES)
    ) u_lane (
      .clk(clk), .rstN(rstN), .strb(strb), .is2d(is2d),
      .startAddr(laneStart[g]),
      .strideField(strideWord[g*STRIDE_W +: STRIDE_W]),
      .incEn(laneInc[g]), .addr(laneAddr[g])
    );
  end

  assign srcAddr = laneAddr[0];
  assign dstAddr = laneAddr[1];

  // R8: last-in-row is never raised once done
  assert_last_not_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(lastInRow && done));
endmodule

// File: tb/sim_stride2d_agen.sv
`timescale 1ns/1ps
module sim_stride2d_agen;
  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] rem;
    logic        dn;
    logic        lst;
  } exp_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic load = 0, is2d = 0, srcInc = 0, dstInc = 0, step = 0;
  logic [31:0] srcAddrIn = 0, dstAddrIn = 0, lenWord = 0, strideWord = 0;
  logic [31:0] srcAddr, dstAddr, remainLen;
  logic lastInRow, done;

  int checks = 0, errors = 0;
  exp_t  expQ[$];
  string tagQ[$];
  bit    finished = 0;

  // reference state kept from the requirements
  logic [13:0] mRows;
  logic [31:0] mBytes, mReload, mSrc, mDst, mSs, mDs;
  logic mMode, mDone;

  always #2.5 clk = ~clk;

  stride2d_agen u0 (
    .clk(clk), .rstN(rstN), .load(load), .is2d(is2d), .srcAddrIn(srcAddrIn),
    .dstAddrIn(dstAddrIn), .lenWord(lenWord), .strideWord(strideWord),
    .srcInc(srcInc), .dstInc(dstInc), .step(step), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .lastInRow(lastInRow), .done(done), .remainLen(remainLen)
  );

  function automatic exp_t snap();
    exp_t e;
    e.src = mSrc; e.dst = mDst;
    e.rem = mMode ? {2'b00, mRows, mBytes[15:0]} : mBytes;
    e.dn  = mDone;
    e.lst = !mDone && (mBytes <= 32'd4);
    return e;
  endfunction

  // driver: one cycle of stimulus, expected state queued for after the edge
  task automatic cyc(input bit ld, input bit md, input logic [31:0] sa, input logic [31:0] da,
                     input logic [31:0] ln, input logic [31:0] sw, input bit si, input bit di,
                     input bit st, input string tag);
    @(negedge clk);
    load = ld; is2d = md; srcAddrIn = sa; dstAddrIn = da; lenWord = ln;
    strideWord = sw; srcInc = si; dstInc = di; step = st;
    if (ld) begin
      mMode   = md;
      mRows   = md ? ln[29:16] : 14'd1;
      mBytes  = md ? {16'd0, ln[15:0]} : ln;
      mReload = mBytes;
      mSrc = sa; mDst = da;
      mSs  = md ? {{16{sw[15]}}, sw[15:0]} : 32'd0;
      mDs  = md ? {{16{sw[31]}}, sw[31:16]} : 32'd0;
      mDone = (mRows == 0) || (mBytes == 0);
    end else if (st && !mDone) begin
      if (si) mSrc = mSrc + 4;
      if (di) mDst = mDst + 4;
      if (mBytes > 4) mBytes = mBytes - 4;
      else if (mRows > 1) begin
        mRows = mRows - 1; mBytes = mReload;
        mSrc = mSrc + mSs; mDst = mDst + mDs;
      end else begin
        mBytes = 0; mDone = 1;
      end
    end
    expQ.push_back(snap());
    tagQ.push_back(tag);
  endtask

  task automatic steps(input int n, input bit si, input bit di, input string tag);
    for (int i = 0; i < n; i++) cyc(0, mMode, 0, 0, 0, 0, si, di, 1, tag);
  endtask

  // monitor: compares one register stage after each queued stimulus
  initial begin
    forever begin
      @(posedge clk); #1;
      if (expQ.size() > 0) begin
        exp_t e, a;
        string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        a = '{srcAddr, dstAddr, remainLen, done, lastInRow};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual src=%h dst=%h rem=%h done=%b last=%b expected src=%h dst=%h rem=%h done=%b last=%b",
                   t, a.src, a.dst, a.rem, a.dn, a.lst, e.src, e.dst, e.rem, e.dn, e.lst);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mRows = 0; mBytes = 0; mReload = 0; mSrc = 0; mDst = 0; mSs = 0; mDs = 0;
    mMode = 0; mDone = 1;
    #12; rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (srcAddr !== 0 || dstAddr !== 0 || remainLen !== 0 || done !== 1 || lastInRow !== 0) begin
      errors++;
      $display("FAIL R1: actual src=%h dst=%h rem=%h done=%b last=%b expected 0 0 0 1 0",
               srcAddr, dstAddr, remainLen, done, lastInRow);
    end
    // R2: 2D load, 3 rows of 8 bytes, dst stride +16, src stride -4
    cyc(1, 1, 32'h1000, 32'h2000, 32'h0003_0008, 32'h0010_FFFC, 1, 1, 0, "R2");
    steps(1, 1, 1, "R5");
    steps(1, 1, 1, "R6");
    steps(2, 1, 1, "R8");
    steps(1, 1, 1, "R6");
    steps(1, 1, 1, "R7");
    // R9: steps after done
    steps(2, 1, 1, "R9");
    // R3 / R5: 1D with only the destination advancing
    cyc(1, 0, 32'h300, 32'h400, 32'd12, 32'h0040_0040, 0, 1, 0, "R3");
    steps(2, 0, 1, "R5");
    steps(1, 0, 1, "R7");
    // R4: zero rows in 2D, zero length in 1D
    cyc(1, 1, 32'h500, 32'h600, 32'h0000_0010, 32'h0, 1, 1, 0, "R4");
    steps(1, 1, 1, "R4");
    cyc(1, 0, 32'h700, 32'h800, 32'd0, 32'h0, 1, 1, 0, "R4");
    steps(1, 1, 1, "R4");
    // R10: load with a step in the same cycle restarts
    cyc(1, 1, 32'hA00, 32'hB00, 32'h0002_0004, 32'hFFF8_0020, 1, 0, 0, "R10");
    steps(1, 1, 0, "R6");
    cyc(1, 1, 32'hC00, 32'hD00, 32'h0002_000C, 32'h0, 1, 1, 1, "R10");
    steps(3, 1, 1, "R10");
    // R11: length not a multiple of four
    cyc(1, 0, 32'h100, 32'h200, 32'd6, 32'h0, 1, 1, 0, "R11");
    steps(2, 1, 1, "R11");
    steps(1, 1, 1, "R9");
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule